// File: doc/BRIEF.md
# Half-Rate Write Data Serializer

This block sits between a memory controller that runs on a slow clock and the memory-side write path that runs on a clock twice as fast, with both clocks in phase. In each controller cycle the block takes one beat. A beat is two memory-width data words, a 2-bit write-valid vector and a 2-bit strobe-enable vector. On every memory clock edge the block sends out one word, one valid bit and one strobe-enable bit. The beat first passes through a write-latency delay. The delay is set in controller cycles and can be changed between bursts.

Each half of a beat is qualified on its own. A burst may therefore start in the upper half of a beat and end in the lower half of a later beat. On the memory side it is still one contiguous run of words. Back-to-back bursts therefore produce no idle memory cycle. The strobe-enable bits follow the same path as the data. A strobe that the controller raises one half ahead of the first valid word leaves the block exactly one memory cycle ahead of it.

Reset is synchronous and active high, shared by both clock domains. It must be released just after a rising controller edge. The first memory edge that sees it low is then the one in the middle of a controller cycle.

Top module: `wser_halfrate_wr`

## Requirements
- R1: While `rst` is high, every memory edge leaves `fr_wdata_o` at zero and leaves `fr_wvld_o` and `fr_stb_en_o` low.
- R2: Within a beat, the lower word (`hr_wdata_i[DATA_W-1:0]`) with valid bit 0 and strobe bit 0 goes out first. The upper word (`hr_wdata_i[2*DATA_W-1:DATA_W]`) with bit 1 of each vector goes out on the next memory cycle.
- R3: Let the latency setting be n (0 to MAX_LAT) and let a beat be presented in controller cycle c. Its lower half is registered at the memory edge in the middle of controller cycle c+n. Its upper half is registered at the memory edge that ends cycle c+n. A setting of 0 adds no controller cycle.
- R4: A beat with valid vector 2'b10 starts an unaligned burst. Only its upper word is sent, and its lower word has no effect on `fr_wdata_o`.
- R5: A beat with valid vector 2'b01 ends an unaligned burst. Only its lower word is sent, and its upper word has no effect on `fr_wdata_o`.
- R6: `fr_wvld_o` equals the valid bit of the half being sent in that memory cycle. Each bit of the valid vector is honoured independently of the other.
- R7: After a memory cycle whose half is not valid, `fr_wvld_o` is low and `fr_wdata_o` keeps the last valid word.
- R8: `fr_stb_en_o` equals the strobe bit of the half being sent, with the same latency as the data. A strobe raised one half before the first valid half appears exactly one memory cycle before `fr_wvld_o` rises.
- R9: A four-word burst occupies four consecutive memory cycles whether it spans two beats (aligned) or three beats (unaligned). Bursts presented back to back produce valid words on consecutive memory cycles with no gap.
- R10: The first memory edge after reset release takes the lower half. The edges then alternate between lower and upper halves, and every lower-half edge falls in the middle of a controller cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctl_clk | input | 1 | Controller (half-rate) clock |
| mem_clk | input | 1 | Memory (full-rate) clock, twice `ctl_clk`, in phase |
| rst | input | 1 | Synchronous active-high reset for both domains |
| wr_lat_i | input | LAT_W | Write latency in controller cycles |
| hr_wdata_i | input | 2*DATA_W | Half-rate write beat, lower word first |
| hr_wvld_i | input | 2 | Per-half write-valid vector |
| hr_stb_en_i | input | 2 | Per-half strobe-enable vector |
| fr_wdata_o | output | DATA_W | Full-rate write word |
| fr_wvld_o | output | 1 | Full-rate write-valid |
| fr_stb_en_o | output | 1 | Full-rate strobe enable |

## Verification
Several properties are checked on every cycle. The reset state is quiet. The data output holds whenever the valid output is low. A latency of one controller cycle reproduces the previous beat exactly. Each rising valid is preceded by an asserted strobe. A cross-domain check ties each memory-side half selection to the controller beat boundary. Other behaviour can only be shown by the bench's scenarios: the order of words across aligned, unaligned and back-to-back bursts, the absolute latency for several settings, and that ignored halves leave the data untouched. Each scenario compares the memory-side word sequence, its start cycle and the strobe lead against a model indexed by controller and memory cycle.

// File: rtl/wser_pkg.sv
package wser_pkg;

    // Number of memory words carried by one controller beat
    localparam int HALVES = 2;

    // Which half of the current beat the memory side is emitting
    typedef enum logic {
        HALF_LO = 1'b0,
        HALF_HI = 1'b1
    } half_sel_t;

    // Per-half qualifiers travelling with a beat
    typedef struct packed {
        logic [HALVES-1:0] vld;
        logic [HALVES-1:0] stb;
    } beat_ctl_t;

    // Limit a requested latency to the depth actually built
    function automatic int clamp_lat(input int req, input int lim);
        return (req > lim) ? lim : req;
    endfunction

endpackage

// File: rtl/wser_lat_pipe.sv
module wser_lat_pipe
    import wser_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int MAX_LAT = 15,
    parameter int LAT_W   = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [LAT_W-1:0]         lat_i,
    input  logic [HALVES*DATA_W-1:0] data_i,
    input  beat_ctl_t                ctl_i,
    output logic [HALVES*DATA_W-1:0] data_o,
    output beat_ctl_t                ctl_o,
    output logic                     beat_tgl_o
);
    localparam int BEAT_W = HALVES * DATA_W;

    logic [BEAT_W-1:0] data_q [MAX_LAT];
    beat_ctl_t         ctl_q  [MAX_LAT];
    logic              tgl_q;

    // Shift chain: one stage per controller cycle of delay
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < MAX_LAT; s++) begin
                data_q[s] <= '0;
                ctl_q[s]  <= '0;
            end
        end else begin
            data_q[0] <= data_i;
            ctl_q[0]  <= ctl_i;
            for (int s = 1; s < MAX_LAT; s++) begin
                data_q[s] <= data_q[s-1];
                ctl_q[s]  <= ctl_q[s-1];
            end
        end
    end

    // Tap selection: zero means the live beat
    always_comb begin
        int eff;
        eff = clamp_lat(int'(lat_i), MAX_LAT);
        if (eff == 0) begin
            data_o = data_i;
            ctl_o  = ctl_i;
        end else begin
            data_o = data_q[eff-1];
            ctl_o  = ctl_q[eff-1];
        end
    end

    // Beat boundary marker seen by the memory domain
    always_ff @(posedge clk) begin
        if (rst) tgl_q <= 1'b1;
        else     tgl_q <= ~tgl_q;
    end
    assign beat_tgl_o = tgl_q;

    AST_ONE_BEAT_DELAY: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) == 1'b0 && lat_i == LAT_W'(1) && $past(lat_i) == LAT_W'(1))
        |-> (data_o == $past(data_i) && ctl_o == $past(ctl_i)))
        else $error("one-beat delay broken"); // R3

endmodule

// File: rtl/wser_phase_gen.sv
module wser_phase_gen
    import wser_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      beat_tgl_i,
    output half_sel_t phase_o
);
    half_sel_t phase_q;
    logic      tgl_seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= HALF_LO;
            tgl_seen_q <= 1'b0;
        end else begin
            phase_q    <= half_sel_t'(~phase_q);
            tgl_seen_q <= beat_tgl_i;
        end
    end

    assign phase_o = phase_q;

    // Lower-half edges must fall where a new controller beat has appeared
    AST_LO_AT_NEW_BEAT: assert property (@(posedge clk) disable iff (rst)
        (phase_q == HALF_LO) |-> (beat_tgl_i != tgl_seen_q))
        else $error("lower half taken off beat boundary"); // R10

    AST_HI_SAME_BEAT: assert property (@(posedge clk) disable iff (rst)
        (phase_q == HALF_HI) |-> (beat_tgl_i == tgl_seen_q))
        else $error("upper half taken from a different beat"); // R10

endmodule

// File: rtl/wser_serializer.sv
module wser_serializer
    import wser_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  half_sel_t                phase_i,
    input  logic [HALVES*DATA_W-1:0] data_i,
    input  beat_ctl_t                ctl_i,
    output logic [DATA_W-1:0]        wdata_o,
    output logic                     wvld_o,
    output logic                     stb_o
);
    logic [DATA_W-1:0] sel_word;
    logic              sel_vld;
    logic              sel_stb;
    logic [DATA_W-1:0] wdata_q;
    logic              wvld_q;
    logic              stb_q;

    // 2:1 selection of the half addressed by the phase bit
    always_comb begin
        sel_word = data_i[int'(phase_i)*DATA_W +: DATA_W];
        sel_vld  = ctl_i.vld[int'(phase_i)];
        sel_stb  = ctl_i.stb[int'(phase_i)];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wdata_q <= '0;
            wvld_q  <= 1'b0;
            stb_q   <= 1'b0;
        end else begin
            wvld_q <= sel_vld;
            stb_q  <= sel_stb;
            if (sel_vld) wdata_q <= sel_word;
        end
    end

    assign wdata_o = wdata_q;
    assign wvld_o  = wvld_q;
    assign stb_o   = stb_q;

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!wvld_q && !stb_q && wdata_q == '0))
        else $error("outputs active under reset"); // R1

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !wvld_q |-> $stable(wdata_q))
        else $error("data moved without valid"); // R7

    AST_STROBE_LEADS: assert property (@(posedge clk) disable iff (rst)
        $rose(wvld_q) |-> $past(stb_q))
        else $error("valid rose without strobe lead"); // R8

endmodule

// File: rtl/wser_halfrate_wr.sv
module wser_halfrate_wr
    import wser_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int MAX_LAT = 15,
    parameter int LAT_W   = $clog2(MAX_LAT + 1)
) (
    input  logic                     ctl_clk,
    input  logic                     mem_clk,
    input  logic                     rst,
    input  logic [LAT_W-1:0]         wr_lat_i,
    input  logic [2*DATA_W-1:0]      hr_wdata_i,
    input  logic [1:0]               hr_wvld_i,
    input  logic [1:0]               hr_stb_en_i,
    output logic [DATA_W-1:0]        fr_wdata_o,
    output logic                     fr_wvld_o,
    output logic                     fr_stb_en_o
);
    localparam int BEAT_W = HALVES * DATA_W;

    beat_ctl_t         in_ctl;
    beat_ctl_t         dly_ctl;
    logic [BEAT_W-1:0] dly_data;
    logic              beat_tgl;
    half_sel_t         phase;

    assign in_ctl.vld = hr_wvld_i;
    assign in_ctl.stb = hr_stb_en_i;

    wser_lat_pipe #(
        .DATA_W (DATA_W),
        .MAX_LAT(MAX_LAT),
        .LAT_W  (LAT_W)
    ) u_pipe (
        .clk       (ctl_clk),
        .rst       (rst),
        .lat_i     (wr_lat_i),
        .data_i    (hr_wdata_i),
        .ctl_i     (in_ctl),
        .data_o    (dly_data),
        .ctl_o     (dly_ctl),
        .beat_tgl_o(beat_tgl)
    );

    wser_phase_gen u_phase (
        .clk       (mem_clk),
        .rst       (rst),
        .beat_tgl_i(beat_tgl),
        .phase_o   (phase)
    );

    wser_serializer #(
        .DATA_W(DATA_W)
    ) u_ser (
        .clk    (mem_clk),
        .rst    (rst),
        .phase_i(phase),
        .data_i (dly_data),
        .ctl_i  (dly_ctl),
        .wdata_o(fr_wdata_o),
        .wvld_o (fr_wvld_o),
        .stb_o  (fr_stb_en_o)
    );

endmodule

// File: tb/test_wser_halfrate_wr.sv
module test_wser_halfrate_wr;
    localparam int MEM_T = 10;
    localparam int W     = 16;
    localparam int NB    = 2048;

    logic          ctl_clk = 1'b0;
    logic          mem_clk = 1'b0;
    logic          rst     = 1'b1;
    logic [3:0]    wr_lat  = '0;
    logic [2*W-1:0] hr_wdata = '0;
    logic [1:0]    hr_wvld = '0;
    logic [1:0]    hr_stb  = '0;
    logic [W-1:0]  fr_wdata;
    logic          fr_wvld;
    logic          fr_stb;

    int checks = 0;
    int errors = 0;

    wser_halfrate_wr #(.DATA_W(W), .MAX_LAT(15)) i_wser_halfrate_wr (
        .ctl_clk    (ctl_clk),
        .mem_clk    (mem_clk),
        .rst        (rst),
        .wr_lat_i   (wr_lat),
        .hr_wdata_i (hr_wdata),
        .hr_wvld_i  (hr_wvld),
        .hr_stb_en_i(hr_stb),
        .fr_wdata_o (fr_wdata),
        .fr_wvld_o  (fr_wvld),
        .fr_stb_en_o(fr_stb)
    );

    always #(MEM_T/2) mem_clk = ~mem_clk;
    initial begin
        #(MEM_T/2);
        forever begin
            ctl_clk = 1'b1; #(MEM_T);
            ctl_clk = 1'b0; #(MEM_T);
        end
    end

    // Reference model state: beats indexed by controller cycle since release
    logic [W-1:0] b_lo [NB];
    logic [W-1:0] b_hi [NB];
    logic [1:0]   b_v  [NB];
    logic [1:0]   b_s  [NB];
    int           cur_c     = 0;
    int           lat_cur   = 0;
    int           mem_edges = 0;
    bit           mon_en    = 1'b0;
    logic [W-1:0] exp_dq    = '0;
    string        cur_tag   = "R1";
    logic [W-1:0] got_w [$];
    int           got_i [$];
    int           first_stb = -1;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge mem_clk) if (mon_en) mem_edges++;

    // Per-memory-cycle comparison against the model
    always @(negedge mem_clk) begin
        if (mon_en) begin
            int m, c, h;
            logic ev, es;
            logic [W-1:0] ew;
            m = mem_edges - 1;
            c = m / 2 - lat_cur;
            h = m % 2;
            ev = 1'b0; es = 1'b0; ew = '0;
            if (c >= 0 && c < NB) begin
                ev = b_v[c][h];
                es = b_s[c][h];
                ew = (h == 1) ? b_hi[c] : b_lo[c];
            end
            if (ev) exp_dq = ew;
            chk(fr_wvld == ev, "R6 valid per half", fr_wvld, ev);
            chk(fr_stb == es, "R8 strobe per half", fr_stb, es);
            chk(fr_wdata == exp_dq, {cur_tag, " data stream"}, fr_wdata, exp_dq);
            if (fr_wvld) begin
                got_w.push_back(fr_wdata);
                got_i.push_back(m);
            end
            if (fr_stb && first_stb < 0) first_stb = m;
        end
    end

    task automatic step(input logic [W-1:0] lo, input logic [W-1:0] hi,
                        input logic [1:0] v, input logic [1:0] s);
        @(posedge ctl_clk);
        cur_c++;
        #1;
        hr_wdata = {hi, lo};
        hr_wvld  = v;
        hr_stb   = s;
        b_lo[cur_c] = lo;
        b_hi[cur_c] = hi;
        b_v[cur_c]  = v;
        b_s[cur_c]  = s;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step('0, '0, 2'b00, 2'b00);
    endtask

    // Drives one word stream (aligned or unaligned) and checks what came out
    task automatic run_stream(input string tag, input int lat, input int nwords,
                              input bit unal, input logic [W-1:0] base);
        int halves, nbeats, start_c, exp_first, off;
        cur_tag = tag;
        idle(20);
        wr_lat  = 4'(lat);
        lat_cur = lat;
        idle(20);
        got_w.delete();
        got_i.delete();
        first_stb = -1;
        off = unal ? 1 : 0;
        if (!unal) step(16'hBAD0, 16'hBAD1, 2'b00, 2'b10);
        halves  = nwords + off;
        nbeats  = (halves + 1) / 2;
        start_c = 0;
        for (int b = 0; b < nbeats; b++) begin
            logic [W-1:0] wd [2];
            logic [1:0] v, s;
            for (int h = 0; h < 2; h++) begin
                int j, k;
                j = 2 * b + h;
                k = j - off;
                if (k >= 0 && k < nwords) begin
                    wd[h] = base + W'(k);
                    v[h]  = 1'b1;
                    s[h]  = 1'b1;
                end else begin
                    wd[h] = 16'hE000 ^ W'(j);
                    v[h]  = 1'b0;
                    s[h]  = (unal && j == 0);
                end
            end
            step(wd[0], wd[1], v, s);
            if (b == 0) start_c = cur_c;
        end
        idle(lat + 4);
        exp_first = 2 * (start_c + lat) + off;
        chk(got_w.size() == nwords, {tag, " R9 word count"}, got_w.size(), nwords);
        for (int i = 0; i < got_w.size(); i++) begin
            chk(got_w[i] == base + W'(i), {tag, " R2 word order"}, got_w[i], base + W'(i));
            chk(got_i[i] == got_i[0] + i, {tag, " R9 contiguous"}, got_i[i], got_i[0] + i);
        end
        if (got_i.size() > 0)
            chk(got_i[0] == exp_first, {tag, " R3 first valid cycle"}, got_i[0], exp_first);
        chk(first_stb == exp_first - 1, {tag, " R8 strobe lead"}, first_stb, exp_first - 1);
        chk(fr_wdata == base + W'(nwords - 1) && !fr_wvld, {tag, " R7 hold after burst"},
            fr_wdata, base + W'(nwords - 1));
    endtask

    task automatic test_reset();
        repeat (4) @(posedge ctl_clk);
        @(negedge mem_clk);
        chk(fr_wvld == 1'b0, "R1 reset valid", fr_wvld, 0);
        chk(fr_stb == 1'b0, "R1 reset strobe", fr_stb, 0);
        chk(fr_wdata == '0, "R1 reset data", fr_wdata, 0);
        @(posedge ctl_clk);
        #1;
        rst    = 1'b0;
        mon_en = 1'b1;
        cur_c  = 0;
    endtask

    task automatic test_aligned_no_latency();   run_stream("R2 R10", 0, 4, 1'b0, 16'h0100); endtask
    task automatic test_aligned_latency();      run_stream("R3", 2, 4, 1'b0, 16'h0200); endtask
    task automatic test_unaligned_start();      run_stream("R4", 2, 4, 1'b1, 16'h0300); endtask
    task automatic test_unaligned_end();        run_stream("R5", 0, 4, 1'b1, 16'h0400); endtask
    task automatic test_single_low();           run_stream("R6", 1, 1, 1'b0, 16'h0500); endtask
    task automatic test_single_high();          run_stream("R6", 3, 1, 1'b1, 16'h0600); endtask
    task automatic test_b2b_aligned();          run_stream("R9", 1, 8, 1'b0, 16'h0700); endtask
    task automatic test_b2b_unaligned();        run_stream("R9", 3, 8, 1'b1, 16'h0800); endtask
    task automatic test_max_latency();          run_stream("R3", 15, 6, 1'b0, 16'h0900); endtask
    task automatic test_max_latency_unal();     run_stream("R4 R5", 15, 5, 1'b1, 16'h0A00); endtask

    initial begin
        for (int i = 0; i < NB; i++) begin
            b_lo[i] = '0; b_hi[i] = '0; b_v[i] = '0; b_s[i] = '0;
        end
        test_reset();
        test_aligned_no_latency();
        test_aligned_latency();
        test_unaligned_start();
        test_unaligned_end();
        test_single_low();
        test_single_high();
        test_b2b_aligned();
        test_b2b_unaligned();
        test_max_latency();
        test_max_latency_unal();
        idle(4);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(MEM_T * 150000);
        checks++;
        errors++;
        $display("FAIL R9 watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule